// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Read Bridge

This block lets a bus master read an external SPI flash as if it were memory. It also keeps a small register port that drives the same serial engine by hand. A single mode bit picks which of the two paths owns the engine, and the two never drive the flash at the same time.

In direct-map mode, each aligned 32-bit read of the window runs a complete flash read on chip-select 0. The bridge sends the read command and a 24-bit byte address, then gathers four data bytes. The bus read is held off until the whole word has arrived.

In register mode, software controls the chip-select and the serial clock divisor, and moves one byte per data-register write. The window then refuses every access. The clock divisor set in register mode is also the one the window reads use.

Top module: `spi_map_bridge`

## Requirements
- R1: After reset the bridge is in direct-map mode. The mode register (offset 0, bit 0) reads 1, `csN` is high, `sclk` is low, and neither ready output is asserted.
- R2: A word read of the window in direct-map mode, with `winSize` = 2 and `winAddr[1:0]` = 0, lowers `csN` and shifts out, MSB first, the command byte 0x03 followed by the 24-bit byte address. The serial mode is 0: `sclk` idles low, `mosi` changes on falling edges and data is sampled on rising edges.
- R3: The four received bytes are returned with the first byte in bits 7:0 and the fourth in bits 31:24. `winReady` is a single-cycle pulse, raised only after all 64 serial bits have been clocked.
- R4: `csN` is high and `sclk` is low when `winReady` pulses for a successful read, and `csN` stays high between accesses.
- R5: A window access with `winSize` other than 2, or with non-zero `winAddr[1:0]`, completes with `winErr` = 1 and `winRdata` = 0, and causes no chip-select activity.
- R6: A window access while in register mode completes with `winErr` = 1 and `winRdata` = 0, and causes no chip-select activity.
- R7: In direct-map mode, an access to register offsets 1 to 3 completes with `regErr` = 1 and `regRdata` = 0. A write made this way has no effect.
- R8: The mode register at offset 0 can be read and written in either mode. Writing bit 0 = 1 selects direct-map mode and bit 0 = 0 selects register mode.
- R9: In register mode, offset 3 bit 0 = 1 drives `csN` low. A write to offset 2 shifts out bits 7:0 of the written data and completes once the byte is done. A read of offset 2 returns the last received byte.
- R10: Each `sclk` half period lasts (D+1) clock cycles, where D is the divisor at offset 1 (reset value 1). Direct-map reads use the same divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regValid | input | 1 | Register request, held until regReady |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 2 | Register offset: 0 mode, 1 divisor, 2 data, 3 chip-select |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, valid with regReady |
| regReady | output | 1 | Register access complete (one cycle) |
| regErr | output | 1 | Register access refused, valid with regReady |
| winValid | input | 1 | Window read request, held until winReady |
| winAddr | input | ADDR_W | Window byte offset |
| winSize | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| winRdata | output | 32 | Window read data, valid with winReady |
| winReady | output | 1 | Window access complete (one cycle) |
| winErr | output | 1 | Window access refused, valid with winReady |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Chip-select 0, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A byte-lane index in the wrong state shows up as a swapped or repeated byte in the very first returned word. A byte counter that is off by one shows up as a wrong bit count at the flash model, or as a missing address byte, when `csN` rises at the end of that same access. A mode bit or chip-select that is wrong shows up at the next access: a window read that should be refused returns data, a register access is refused when it should not be, or `csN` falls when no transfer is allowed. A divisor that is not applied shows up in the width of the first `sclk` pulse after the divisor is written.

// File: rtl/spi_map_pkg.sv
package spi_map_pkg;
  localparam int FLASH_AW = 24;

  typedef enum logic [2:0] {
    TX_CMD, TX_ADDR_HI, TX_ADDR_MID, TX_ADDR_LO, TX_ZERO, TX_REG
  } txSrc_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_RXFER, S_SEND, S_RECV, S_GAP
  } state_e;

  typedef struct packed {
    logic       startByte;
    txSrc_e     txSel;
    logic       captureEn;
    logic [1:0] captureLane;
    logic       latchAddr;
    logic       loadDiv;
    logic       loadTx;
  } strobes_t;
endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       txByte,
  input  logic [DIV_W-1:0] divValue,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic [7:0]       rxByte,
  output logic             done
);
  logic             busy;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       bitIdx;
  logic [7:0]       txSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; sclk <= 1'b0; cnt <= '0; bitIdx <= '0;
      txSh <= '0; rxByte <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1; txSh <= txByte; cnt <= '0; bitIdx <= '0; sclk <= 1'b0;
      end else if (busy) begin
        if (cnt == divValue) begin
          cnt  <= '0;
          sclk <= ~sclk;
          if (!sclk) begin
            rxByte <= {rxByte[6:0], miso};
          end else if (bitIdx == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitIdx <= bitIdx + 3'd1;
            txSh   <= {txSh[6:0], 1'b0};
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign mosi = busy & txSh[7];
endmodule

// File: rtl/spi_map_datapath.sv
module spi_map_datapath
  import spi_map_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 1,
  parameter logic [7:0] READ_CMD = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strobes,
  input  logic [ADDR_W-1:0] winAddr,
  input  logic [7:0]        wrByte,
  input  logic [DIV_W-1:0]  wrDiv,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              byteDone,
  output logic [7:0]        rxLast,
  output logic [DIV_W-1:0]  divValue,
  output logic [31:0]       wordData
);
  logic [FLASH_AW-1:0] addrQ;
  logic [7:0]          txHold;
  logic [7:0]          txByte;
  logic [7:0]          rxByte;
  logic [FLASH_AW-1:0] alignedAddr;

  assign alignedAddr = FLASH_AW'(winAddr) & ~FLASH_AW'(3);

  always_comb begin
    case (strobes.txSel)
      TX_CMD:      txByte = READ_CMD;
      TX_ADDR_HI:  txByte = addrQ[23:16];
      TX_ADDR_MID: txByte = addrQ[15:8];
      TX_ADDR_LO:  txByte = addrQ[7:0];
      TX_REG:      txByte = txHold;
      default:     txByte = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0; txHold <= '0; rxLast <= '0; wordData <= '0;
      divValue <= DIV_W'(DIV_RESET);
    end else begin
      if (strobes.latchAddr) addrQ <= alignedAddr;
      if (strobes.loadTx)    txHold <= wrByte;
      if (strobes.loadDiv)   divValue <= wrDiv;
      if (byteDone)          rxLast <= rxByte;
      if (strobes.captureEn) wordData[strobes.captureLane*8 +: 8] <= rxByte;
    end
  end

  spi_byte_engine #(.DIV_W(DIV_W)) u_engine (
    .clk(clk), .rstN(rstN), .start(strobes.startByte), .txByte(txByte),
    .divValue(divValue), .miso(miso), .sclk(sclk), .mosi(mosi),
    .rxByte(rxByte), .done(byteDone)
  );
endmodule

// File: rtl/spi_map_ctrl.sv
module spi_map_ctrl
  import spi_map_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DIV_W     = 8,
  parameter bit RESET_MAP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [1:0]        regAddr,
  input  logic              wrBit,
  output logic [31:0]       regRdata,
  output logic              regReady,
  output logic              regErr,
  input  logic              winValid,
  input  logic [1:0]        winLow,
  input  logic [1:0]        winSize,
  output logic              winReady,
  output logic              winErr,
  input  logic              byteDone,
  input  logic [7:0]        rxLast,
  input  logic [DIV_W-1:0]  divValue,
  output logic              csN,
  output strobes_t          strobes
);
  localparam logic [1:0] OFF_MODE = 2'd0;
  localparam logic [1:0] OFF_DIV  = 2'd1;
  localparam logic [1:0] OFF_DATA = 2'd2;
  localparam logic [1:0] OFF_CS   = 2'd3;

  state_e     state;
  logic       mapMode, csReg, launched;
  logic [1:0] idx;
  logic [31:0] readMux;
  logic        winBad;

  assign winBad = !mapMode || (winSize != 2'd2) || (winLow != 2'b00);

  always_comb begin
    case (regAddr)
      OFF_MODE: readMux = {31'b0, mapMode};
      OFF_DIV:  readMux = 32'(divValue);
      OFF_DATA: readMux = {24'b0, rxLast};
      default:  readMux = {31'b0, csReg};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE; mapMode <= RESET_MAP; csReg <= 1'b0; launched <= 1'b0;
      idx <= '0; regReady <= 1'b0; regErr <= 1'b0; regRdata <= '0;
      winReady <= 1'b0; winErr <= 1'b0;
    end else begin
      regReady <= 1'b0;
      winReady <= 1'b0;
      case (state)
        S_IDLE: begin
          if (regValid) begin
            if (mapMode && regAddr != OFF_MODE) begin
              regErr <= 1'b1; regRdata <= '0; regReady <= 1'b1; state <= S_HOLD;
            end else if (regWrite && regAddr == OFF_DATA) begin
              launched <= 1'b0; state <= S_RXFER;
            end else begin
              regErr <= 1'b0; regReady <= 1'b1; state <= S_HOLD;
              regRdata <= regWrite ? '0 : readMux;
              if (regWrite && regAddr == OFF_MODE) mapMode <= wrBit;
              if (regWrite && regAddr == OFF_CS)   csReg <= wrBit;
            end
          end else if (winValid) begin
            if (winBad) begin
              winErr <= 1'b1; winReady <= 1'b1; state <= S_HOLD;
            end else begin
              winErr <= 1'b0; idx <= '0; launched <= 1'b0; state <= S_SEND;
            end
          end
        end
        S_RXFER: begin
          if (!launched) launched <= 1'b1;
          else if (byteDone) begin
            regErr <= 1'b0; regRdata <= '0; regReady <= 1'b1; state <= S_HOLD;
          end
        end
        S_SEND, S_RECV: begin
          if (!launched) launched <= 1'b1;
          else if (byteDone) begin
            launched <= 1'b0;
            idx <= idx + 2'd1;
            if (idx == 2'd3) state <= (state == S_SEND) ? S_RECV : S_GAP;
          end
        end
        S_GAP: begin
          winReady <= 1'b1; state <= S_HOLD;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes = '0;
    strobes.txSel = TX_ZERO;
    strobes.startByte = (state == S_SEND || state == S_RECV || state == S_RXFER) && !launched;
    if (state == S_SEND) begin
      case (idx)
        2'd0:    strobes.txSel = TX_CMD;
        2'd1:    strobes.txSel = TX_ADDR_HI;
        2'd2:    strobes.txSel = TX_ADDR_MID;
        default: strobes.txSel = TX_ADDR_LO;
      endcase
    end else if (state == S_RXFER) begin
      strobes.txSel = TX_REG;
    end
    strobes.captureEn   = (state == S_RECV) && launched && byteDone;
    strobes.captureLane = idx;
    strobes.latchAddr   = (state == S_IDLE) && !regValid && winValid;
    strobes.loadDiv     = (state == S_IDLE) && regValid && regWrite && !mapMode && regAddr == OFF_DIV;
    strobes.loadTx      = (state == S_IDLE) && regValid && regWrite && !mapMode && regAddr == OFF_DATA;
  end

  assign csN = (state == S_SEND || state == S_RECV) ? 1'b0 : (mapMode ? 1'b1 : !csReg);
endmodule

// File: rtl/spi_map_bridge.sv
module spi_map_bridge
  import spi_map_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DIV_W     = 8,
  parameter int DIV_RESET = 1,
  parameter bit RESET_MAP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [1:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              regReady,
  output logic              regErr,
  input  logic              winValid,
  input  logic [ADDR_W-1:0] winAddr,
  input  logic [1:0]        winSize,
  output logic [31:0]       winRdata,
  output logic              winReady,
  output logic              winErr,
  output logic              sclk,
  output logic              csN,
  output logic              mosi,
  input  logic              miso
);
  strobes_t         strobes;
  logic             byteDone;
  logic [7:0]       rxLast;
  logic [DIV_W-1:0] divValue;
  logic [31:0]      wordData;
  logic             unusedWdata;

  assign unusedWdata = ^regWdata[31:8];

  spi_map_ctrl #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .RESET_MAP(RESET_MAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .wrBit(regWdata[0]), .regRdata(regRdata),
    .regReady(regReady), .regErr(regErr), .winValid(winValid),
    .winLow(winAddr[1:0]), .winSize(winSize), .winReady(winReady),
    .winErr(winErr), .byteDone(byteDone), .rxLast(rxLast),
    .divValue(divValue), .csN(csN), .strobes(strobes)
  );

  spi_map_datapath #(.ADDR_W(ADDR_W), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .winAddr(winAddr),
    .wrByte(regWdata[7:0]), .wrDiv(regWdata[DIV_W-1:0]), .miso(miso),
    .sclk(sclk), .mosi(mosi), .byteDone(byteDone), .rxLast(rxLast),
    .divValue(divValue), .wordData(wordData)
  );

  assign winRdata = (winReady && !winErr) ? wordData : 32'h0;
endmodule

// File: rtl/spi_map_bridge_checker.sv
module spi_map_bridge_checker (
  input logic        clk,
  input logic        rstN,
  input logic        winReady,
  input logic        winErr,
  input logic [31:0] winRdata,
  input logic        regReady,
  input logic        regErr,
  input logic [31:0] regRdata,
  input logic        csN,
  input logic        sclk
);
  assert_win_err_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (winReady && winErr) |-> (winRdata == 32'h0));

  assert_reg_err_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (regReady && regErr) |-> (regRdata == 32'h0));

  assert_cs_released_R4: assert property (@(posedge clk) disable iff (!rstN)
    (winReady && !winErr) |-> (csN && !sclk));

  assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    winReady |=> !winReady);

  assert_one_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({winReady, regReady}));
endmodule

bind spi_map_bridge spi_map_bridge_checker u_checker (
  .clk(clk), .rstN(rstN), .winReady(winReady), .winErr(winErr),
  .winRdata(winRdata), .regReady(regReady), .regErr(regErr),
  .regRdata(regRdata), .csN(csN), .sclk(sclk)
);

// File: tb/spi_map_bridge_bench.sv
module spi_map_bridge_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic regValid = 0, regWrite = 0, winValid = 0, miso = 0;
  logic [1:0] regAddr = 0, winSize = 0;
  logic [31:0] regWdata = 0;
  logic [23:0] winAddr = 0;
  logic [31:0] regRdata, winRdata;
  logic regReady, regErr, winReady, winErr, sclk, csN, mosi;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  spi_map_bridge u_spi_map_bridge (.*);

  function automatic logic [7:0] memByte(input logic [23:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction
  function automatic logic [31:0] memWord(input logic [23:0] a);
    return {memByte(a + 24'd3), memByte(a + 24'd2), memByte(a + 24'd1), memByte(a)};
  endfunction

  // flash model
  int bitCnt = 0, lastBits = 0, csFalls = 0, hiCnt = 0, lastHigh = 0;
  logic [31:0] hdr = 0;
  logic [7:0] cmdSeen = 0;
  logic [23:0] addrSeen = 0;
  always @(posedge sclk or posedge csN) begin
    if (csN) begin
      if (bitCnt != 0) lastBits = bitCnt;
      bitCnt = 0;
    end else begin
      if (bitCnt < 32) hdr = {hdr[30:0], mosi};
      bitCnt++;
      if (bitCnt == 32) begin cmdSeen = hdr[31:24]; addrSeen = hdr[23:0]; end
    end
  end
  always @(negedge sclk) begin
    if (!csN && bitCnt >= 32) begin
      automatic int k = bitCnt - 32;
      automatic logic [7:0] b = memByte(addrSeen + 24'(k / 8));
      miso = b[7 - (k % 8)];
    end
  end
  always @(negedge csN) csFalls++;
  always @(posedge clk) begin
    if (sclk) hiCnt++;
    else if (hiCnt != 0) begin lastHigh = hiCnt; hiCnt = 0; end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regAcc(input bit wr, input logic [1:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    regValid = 1; regWrite = wr; regAddr = a; regWdata = d;
    do @(negedge clk); while (!regReady);
    rd = regRdata; er = regErr; regValid = 0;
  endtask

  task automatic winRead(input logic [23:0] a, input logic [1:0] sz,
                         output logic [31:0] rd, output logic er, output int waited);
    waited = 0;
    @(negedge clk);
    winValid = 1; winAddr = a; winSize = sz;
    do begin @(negedge clk); waited++; end while (!winReady);
    rd = winRdata; er = winErr; winValid = 0;
    check(csN === 1'b1 && sclk === 1'b0, "R4 cs high at ack", {30'b0, csN, sclk}, 32'h2);
  endtask

  logic [31:0] rd;
  logic er;
  int w, curDiv = 1;

  task automatic setDiv(input int d);
    regAcc(1, 2'd0, 0, rd, er);
    regAcc(1, 2'd1, 32'(d), rd, er);
    regAcc(0, 2'd1, 0, rd, er);
    check(rd == 32'(d) && !er, "R10 divisor readback", rd, 32'(d));
    regAcc(1, 2'd0, 1, rd, er);
    curDiv = d;
  endtask

  task automatic goodRead(input logic [23:0] a);
    winRead(a, 2'd2, rd, er, w);
    check(!er && rd == memWord(a), "R3 word data", rd, memWord(a));
    check(cmdSeen == 8'h03 && addrSeen == a, "R2 command and address", {cmdSeen, addrSeen}, {8'h03, a});
    check(lastBits == 64, "R2 serial bit count", 32'(lastBits), 32'd64);
    check(w >= 128 * (curDiv + 1), "R3 stall until word received", 32'(w), 32'(128 * (curDiv + 1)));
    check(lastHigh == curDiv + 1, "R10 sclk half period", 32'(lastHigh), 32'(curDiv + 1));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    @(negedge clk);
    check(csN === 1 && sclk === 0 && winReady === 0 && regReady === 0, "R1 reset outputs",
          {28'b0, csN, sclk, winReady, regReady}, 32'h8);
    regAcc(0, 2'd0, 0, rd, er);
    check(rd == 1 && !er, "R1 reset mode reads map", rd, 1);

    goodRead(24'h000000);
    goodRead(24'hFFFFFC);
    goodRead(24'h12345C);

    begin
      automatic int f0 = csFalls;
      winRead(24'h000102, 2'd2, rd, er, w);
      check(er && rd == 0, "R5 unaligned refused", rd, 0);
      winRead(24'h000100, 2'd0, rd, er, w);
      check(er && rd == 0, "R5 byte size refused", rd, 0);
      winRead(24'h000100, 2'd1, rd, er, w);
      check(er && rd == 0, "R5 halfword refused", rd, 0);
      check(csFalls == f0, "R5 no flash activity", 32'(csFalls), 32'(f0));
    end

    regAcc(1, 2'd1, 32'd7, rd, er);
    check(er && rd == 0, "R7 divisor write refused in map mode", {31'b0, er}, 1);
    regAcc(0, 2'd1, 0, rd, er);
    check(er && rd == 0, "R7 divisor read refused", rd, 0);
    regAcc(0, 2'd2, 0, rd, er);
    check(er && rd == 0, "R7 data read refused", rd, 0);
    regAcc(1, 2'd0, 0, rd, er);
    check(!er, "R8 mode write accepted", {31'b0, er}, 0);
    regAcc(0, 2'd0, 0, rd, er);
    check(rd == 0 && !er, "R8 mode reads register", rd, 0);
    regAcc(0, 2'd1, 0, rd, er);
    check(rd == 1 && !er, "R7 divisor unchanged", rd, 1);

    begin
      automatic int f0 = csFalls;
      winRead(24'h000040, 2'd2, rd, er, w);
      check(er && rd == 0 && csFalls == f0, "R6 window refused in register mode", rd, 0);
    end

    // manual transfer in register mode
    regAcc(1, 2'd3, 1, rd, er);
    @(negedge clk);
    check(csN === 0, "R9 chip-select driven low", {31'b0, csN}, 0);
    regAcc(1, 2'd2, 32'h03, rd, er);
    regAcc(1, 2'd2, 32'h00, rd, er);
    regAcc(1, 2'd2, 32'h00, rd, er);
    regAcc(1, 2'd2, 32'h40, rd, er);
    check(cmdSeen == 8'h03 && addrSeen == 24'h40, "R9 bytes shifted out", {cmdSeen, addrSeen}, 32'h03000040);
    regAcc(1, 2'd2, 32'hFF00, rd, er);
    regAcc(0, 2'd2, 0, rd, er);
    check(rd == 32'(memByte(24'h40)) && !er, "R9 received byte 0", rd, 32'(memByte(24'h40)));
    regAcc(1, 2'd2, 32'h00, rd, er);
    regAcc(0, 2'd2, 0, rd, er);
    check(rd == 32'(memByte(24'h41)), "R9 received byte 1", rd, 32'(memByte(24'h41)));
    regAcc(1, 2'd3, 0, rd, er);
    @(negedge clk);
    check(csN === 1, "R9 chip-select released", {31'b0, csN}, 1);
    regAcc(1, 2'd0, 1, rd, er);
    regAcc(0, 2'd0, 0, rd, er);
    check(rd == 1, "R8 back to map mode", rd, 1);

    setDiv(0);
    goodRead(24'h0000F0);
    setDiv(3);
    goodRead(24'hABCDE8);

    for (int i = 0; i < 40; i++) begin
      automatic logic [23:0] a = 24'($urandom);
      automatic int pick = $urandom_range(0, 4);
      if (i % 10 == 0) setDiv($urandom_range(0, 2));
      if (pick == 0) begin
        automatic int f0 = csFalls;
        automatic logic [1:0] sz = (a[1:0] == 0) ? 2'd1 : 2'd2;
        winRead(a, sz, rd, er, w);
        check(er && rd == 0 && csFalls == f0, "R5 random refused access", rd, 0);
      end else begin
        goodRead({a[23:2], 2'b00});
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule